// File: doc/BRIEF.md
# Masked Circular-Buffer Address Generator

This block forms operand addresses for the load and store side of a multiply-accumulate engine. A request names one of eight 32-bit address registers and picks one of four addressing modes: plain indirect, indirect with post-increment, indirect with pre-decrement, or indirect plus a signed 16-bit offset. The operand address appears combinationally in the request cycle. Any register update is reported on the writeback pins in that same cycle and is stored at the next clock edge.

A per-request enable can apply a software-held mask to the address. Only the low half of the address is masked; the upper half passes unchanged. When the mask holds 2^k − 1 in its low bits, a register walked in post-increment mode wraps inside a 2^k-byte window. This gives a circular queue with no compare logic. The 32-bit mask register always reads its upper half as ones. Address registers are loaded through a plain load port, and any of them can be read back through a read port.

The request strobe is a plain control input. There is no back-pressure: every cycle in which `req_i` is high is taken as one request, so the address and writeback outputs are valid only in that cycle. A request with no register update leaves the register bank untouched.

Top module: `circ_agu`

## Requirements
- R1: After reset, the mask register reads 0xFFFFFFFF and every address register reads 0.
- R2: A mask write stores the low 16 bits of the write data. Bits 31–16 of the write data are ignored, and the mask always reads back as {16'hFFFF, stored bits}.
- R3: Mode 0 (indirect): the address is An AND the effective mask, and there is no writeback. With masking enabled the effective mask is {16'hFFFF, mask[15:0]}; with masking disabled it is all ones.
- R4: Mode 1 (post-increment): the address is An with no mask applied, and An is updated to (An + 4) AND the effective mask.
- R5: Mode 2 (pre-decrement): the address and the new An both equal (An − 4) AND the effective mask.
- R6: Mode 3 (offset): the 16-bit offset is sign-extended to 32 bits. The address is (An + offset) AND the effective mask, and there is no writeback.
- R7: When `mask_en_i` is 0, every mode produces the same address and update it would produce with an all-ones mask.
- R8: All address arithmetic wraps modulo 2^32.
- R9: A request in the same cycle as a mask write uses the mask value held before the write.
- R10: A register update is stored at the clock edge that ends the request cycle. If a load to the same register occurs in that cycle, the request's update takes precedence over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Address request strobe |
| mode_i | input | 2 | Addressing mode: 0 indirect, 1 post-increment, 2 pre-decrement, 3 offset |
| areg_i | input | 3 | Index of the address register used |
| disp_i | input | 16 | Signed offset for mode 3 |
| mask_en_i | input | 1 | Enables masking for this request |
| addr_o | output | 32 | Operand address |
| wb_en_o | output | 1 | Register update takes place at the next edge |
| wb_idx_o | output | 3 | Index of the register being updated |
| wb_data_o | output | 32 | New register value |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 32 | Mask write data |
| mask_rd_o | output | 32 | Mask register read value |
| ld_en_i | input | 1 | Address register load strobe |
| ld_idx_i | input | 3 | Index of the register to load |
| ld_data_i | input | 32 | Load data |
| rd_idx_i | input | 3 | Index of the register to read back |
| rd_data_o | output | 32 | Read-back register value |

## Verification
Each of the four modes is driven both with and without masking. Register values are chosen so that a masked address differs from an unmasked one. This separates a mask that is applied to the wrong result, for example the post-increment address instead of its update, from a mask that is applied correctly. Register values near zero and near 2^32, together with negative offsets, expose incorrect sign extension and incorrect wrap-around. Collisions in a single cycle are also driven: a mask write together with a request, and a load together with an update of the same register. These show which write wins. A long run of mixed random requests, loads and mask writes is compared clock by clock against a behavioural model of the registers.

// File: rtl/circ_agu_pkg.sv
package circ_agu_pkg;
  typedef enum logic [1:0] {
    MODE_IND  = 2'd0,
    MODE_POST = 2'd1,
    MODE_PRE  = 2'd2,
    MODE_DISP = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/circ_agu_mask_reg.sv
module circ_agu_mask_reg #(
  parameter int AW = 32,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] wdata_i,
  output logic [MW-1:0] mask_lo_o,
  output logic [AW-1:0] rd_o
);
  localparam int HW = AW - MW;

  logic [MW-1:0] lo_q;
  logic          unused_upper;

  assign unused_upper = ^wdata_i[AW-1:MW];

  always_ff @(posedge clk) begin
    if (!rst_n)    lo_q <= '1;
    else if (wr_i) lo_q <= wdata_i[MW-1:0];
  end

  assign mask_lo_o = lo_q;
  assign rd_o      = {{HW{1'b1}}, lo_q};

  // R2: a write lands in the low field on the next edge
  a_r2_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_i) |-> rd_o[MW-1:0] == $past(wdata_i[MW-1:0]));
endmodule

// File: rtl/circ_agu_regfile.sv
module circ_agu_regfile #(
  parameter int AW    = 32,
  parameter int NREGS = 8,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] a_idx_i,
  output logic [AW-1:0] a_data_o,
  input  logic [IW-1:0] b_idx_i,
  output logic [AW-1:0] b_data_o,
  input  logic          upd_en_i,
  input  logic [IW-1:0] upd_idx_i,
  input  logic [AW-1:0] upd_val_i,
  input  logic          ld_en_i,
  input  logic [IW-1:0] ld_idx_i,
  input  logic [AW-1:0] ld_data_i
);
  logic [AW-1:0] q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[g] <= '0;
      else if (upd_en_i && upd_idx_i == IW'(g))
        q[g] <= upd_val_i;
      else if (ld_en_i && ld_idx_i == IW'(g))
        q[g] <= ld_data_i;
    end
  end

  assign a_data_o = q[a_idx_i];
  assign b_data_o = q[b_idx_i];

  // R10: an update is stored at the following edge, ahead of any load
  a_r10_update_lands: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(upd_en_i) |-> q[$past(upd_idx_i)] == $past(upd_val_i));
endmodule

// File: rtl/circ_agu_calc.sv
module circ_agu_calc
  import circ_agu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int MW   = 16,
  parameter int DW   = 16,
  parameter int STEP = 4
) (
  input  agu_mode_e     mode_i,
  input  logic [AW-1:0] an_i,
  input  logic [DW-1:0] disp_i,
  input  logic          mask_en_i,
  input  logic [MW-1:0] mask_lo_i,
  output logic [AW-1:0] addr_o,
  output logic          upd_en_o,
  output logic [AW-1:0] upd_val_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] eff, sext, inc, dec, sum;

  assign eff  = mask_en_i ? {{(AW-MW){1'b1}}, mask_lo_i} : '1;
  assign sext = {{(AW-DW){disp_i[DW-1]}}, disp_i};
  assign inc  = an_i + STEP_V;
  assign dec  = an_i - STEP_V;
  assign sum  = an_i + sext;

  always_comb begin
    addr_o    = an_i & eff;
    upd_en_o  = 1'b0;
    upd_val_o = an_i;
    unique case (mode_i)
      MODE_IND: ;
      MODE_POST: begin
        addr_o    = an_i;
        upd_en_o  = 1'b1;
        upd_val_o = inc & eff;
      end
      MODE_PRE: begin
        addr_o    = dec & eff;
        upd_en_o  = 1'b1;
        upd_val_o = dec & eff;
      end
      MODE_DISP: addr_o = sum & eff;
      default: ;
    endcase
  end
endmodule

// File: rtl/circ_agu.sv
module circ_agu
  import circ_agu_pkg::*;
#(
  parameter int AW    = 32,
  parameter int MW    = 16,
  parameter int DW    = 16,
  parameter int NREGS = 8,
  parameter int STEP  = 4,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [1:0]    mode_i,
  input  logic [IW-1:0] areg_i,
  input  logic [DW-1:0] disp_i,
  input  logic          mask_en_i,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [IW-1:0] wb_idx_o,
  output logic [AW-1:0] wb_data_o,
  input  logic          mask_wr_i,
  input  logic [AW-1:0] mask_wdata_i,
  output logic [AW-1:0] mask_rd_o,
  input  logic          ld_en_i,
  input  logic [IW-1:0] ld_idx_i,
  input  logic [AW-1:0] ld_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o
);
  logic [MW-1:0] mask_lo;
  logic [AW-1:0] an;
  logic          upd_en;
  agu_mode_e     mode;

  assign mode = agu_mode_e'(mode_i);

  circ_agu_mask_reg #(.AW(AW), .MW(MW)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(mask_wr_i), .wdata_i(mask_wdata_i),
    .mask_lo_o(mask_lo), .rd_o(mask_rd_o)
  );

  circ_agu_calc #(.AW(AW), .MW(MW), .DW(DW), .STEP(STEP)) u_calc (
    .mode_i(mode), .an_i(an), .disp_i(disp_i), .mask_en_i(mask_en_i),
    .mask_lo_i(mask_lo), .addr_o(addr_o), .upd_en_o(upd_en),
    .upd_val_o(wb_data_o)
  );

  assign wb_en_o  = req_i & upd_en;
  assign wb_idx_o = areg_i;

  circ_agu_regfile #(.AW(AW), .NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .a_idx_i(areg_i), .a_data_o(an),
    .b_idx_i(rd_idx_i), .b_data_o(rd_data_o),
    .upd_en_i(wb_en_o), .upd_idx_i(areg_i), .upd_val_i(wb_data_o),
    .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i)
  );

  // R3: indirect requests never update a register
  a_r3_ind_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && mode_i == 2'd0 |-> !wb_en_o);

  // R6: offset requests never update a register
  a_r6_disp_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && mode_i == 2'd3 |-> !wb_en_o);

  // R5: pre-decrement address equals the new register value
  a_r5_pre_match: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && mode_i == 2'd2 |-> wb_en_o && addr_o == wb_data_o);

  // R4: unmasked post-increment steps the register by one word past the address
  a_r4_post_step: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && mode_i == 2'd1 && !mask_en_i |-> wb_data_o == addr_o + AW'(STEP));
endmodule

// File: tb/circ_agu_tb.sv
module circ_agu_tb;
  logic        clk = 0, rst_n = 0;
  logic        req_i = 0, mask_en_i = 0, mask_wr_i = 0, ld_en_i = 0;
  logic [1:0]  mode_i = 0;
  logic [2:0]  areg_i = 0, ld_idx_i = 0, rd_idx_i = 0;
  logic [15:0] disp_i = 0;
  logic [31:0] mask_wdata_i = 0, ld_data_i = 0;
  logic [31:0] addr_o, wb_data_o, mask_rd_o, rd_data_o;
  logic        wb_en_o;
  logic [2:0]  wb_idx_o;

  always #5 clk = ~clk;

  circ_agu u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i), .areg_i(areg_i),
    .disp_i(disp_i), .mask_en_i(mask_en_i), .addr_o(addr_o), .wb_en_o(wb_en_o),
    .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o), .mask_wr_i(mask_wr_i),
    .mask_wdata_i(mask_wdata_i), .mask_rd_o(mask_rd_o), .ld_en_i(ld_en_i),
    .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i), .rd_idx_i(rd_idx_i),
    .rd_data_o(rd_data_o)
  );

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] m_regs [8];
  logic [15:0] m_mask;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog R10 actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] md, input logic [31:0] an, input logic [15:0] dp,
                       input bit me, output logic [31:0] ad, output bit wb, output logic [31:0] nv);
    logic [31:0] m, off;
    m   = me ? {16'hFFFF, m_mask} : 32'hFFFF_FFFF;
    off = {{16{dp[15]}}, dp};
    wb  = 0; nv = an;
    case (md)
      2'd0: ad = an & m;
      2'd1: begin ad = an; wb = 1; nv = (an + 32'd4) & m; end
      2'd2: begin ad = (an - 32'd4) & m; wb = 1; nv = ad; end
      default: ad = (an + off) & m;
    endcase
  endtask

  task automatic step(input bit rq, input logic [1:0] md, input logic [2:0] ix,
                      input logic [15:0] dp, input bit me, input bit mw, input logic [31:0] mwd,
                      input bit ld, input logic [2:0] li, input logic [31:0] ldd, input string tag);
    logic [31:0] ead, env; bit ewb;
    @(negedge clk);
    req_i = rq; mode_i = md; areg_i = ix; disp_i = dp; mask_en_i = me;
    mask_wr_i = mw; mask_wdata_i = mwd; ld_en_i = ld; ld_idx_i = li; ld_data_i = ldd;
    #1;
    model(md, m_regs[ix], dp, me, ead, ewb, env);
    check(wb_en_o == (rq && ewb), {tag, " wb_en"}, 32'(wb_en_o), 32'(rq && ewb));
    if (rq) check(addr_o == ead, {tag, " addr"}, addr_o, ead);
    if (rq && ewb) begin
      check(wb_data_o == env, {tag, " wb_data"}, wb_data_o, env);
      check(wb_idx_o == ix, {tag, " wb_idx"}, 32'(wb_idx_o), 32'(ix));
    end
    @(posedge clk);
    if (ld) m_regs[li] = ldd;
    if (rq && ewb) m_regs[ix] = env;
    if (mw) m_mask = mwd[15:0];
    @(negedge clk);
    req_i = 0; mask_wr_i = 0; ld_en_i = 0;
  endtask

  task automatic chk_reg(input logic [2:0] i, input string tag);
    @(negedge clk);
    req_i = 0; mask_wr_i = 0; ld_en_i = 0; rd_idx_i = i;
    #1;
    check(rd_data_o == m_regs[i], {tag, " regread"}, rd_data_o, m_regs[i]);
  endtask

  task automatic chk_mask(input string tag);
    #1;
    check(mask_rd_o == {16'hFFFF, m_mask}, {tag, " maskread"}, mask_rd_o, {16'hFFFF, m_mask});
  endtask

  task automatic load(input logic [2:0] i, input logic [31:0] v);
    step(0, 0, 0, 0, 0, 0, 0, 1, i, v, "R10 load");
  endtask

  initial begin
    string mtag [4] = '{"R3", "R4", "R5", "R6"};
    for (int i = 0; i < 8; i++) m_regs[i] = '0;
    m_mask = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk_mask("R1");
    for (int i = 0; i < 8; i++) chk_reg(3'(i), "R1");
    // R2 upper write bits ignored
    step(0, 0, 0, 0, 0, 1, 32'h1234_00FF, 0, 0, 0, "R2");
    chk_mask("R2");
    // R3 indirect masked and unmasked
    load(1, 32'hABCD_1357);
    step(1, 2'd0, 1, 0, 1, 0, 0, 0, 0, 0, "R3 masked");
    step(1, 2'd0, 1, 0, 0, 0, 0, 0, 0, 0, "R7 R3 unmasked");
    chk_reg(1, "R3");
    // R4 circular walk in a 256-byte window
    load(2, 32'h0000_20F8);
    for (int k = 0; k < 4; k++) step(1, 2'd1, 2, 0, 1, 0, 0, 0, 0, 0, "R4 walk");
    chk_reg(2, "R4");
    step(1, 2'd1, 2, 0, 0, 0, 0, 0, 0, 0, "R7 R4 unmasked");
    // R5 pre-decrement masked
    load(3, 32'h0000_5500);
    step(1, 2'd2, 3, 0, 1, 0, 0, 0, 0, 0, "R5 masked");
    chk_reg(3, "R5");
    // R6 negative and positive offsets
    load(4, 32'h0000_0100);
    step(1, 2'd3, 4, 16'hFFF0, 0, 0, 0, 0, 0, 0, "R6 neg");
    step(1, 2'd3, 4, 16'h7FFF, 1, 0, 0, 0, 0, 0, "R6 pos masked");
    chk_reg(4, "R6");
    // R8 wrap-around
    load(5, 32'hFFFF_FFFE);
    step(1, 2'd1, 5, 0, 0, 0, 0, 0, 0, 0, "R8 inc wrap");
    load(6, 32'h0);
    step(1, 2'd2, 6, 0, 0, 0, 0, 0, 0, 0, "R8 dec wrap");
    step(1, 2'd3, 5, 16'h8000, 0, 0, 0, 0, 0, 0, "R8 disp wrap");
    // R9 mask write with request
    step(1, 2'd0, 1, 0, 1, 1, 32'h0000_000F, 0, 0, 0, "R9 old mask");
    chk_mask("R9");
    step(1, 2'd0, 1, 0, 1, 0, 0, 0, 0, 0, "R9 new mask");
    // R10 load collides with update
    step(1, 2'd1, 7, 0, 0, 0, 0, 1, 7, 32'hDEAD_BEEF, "R10 collide");
    chk_reg(7, "R10");
    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [1:0] md; md = 2'($urandom % 4);
      step($urandom % 4 != 0, md, 3'($urandom), 16'($urandom), 1'($urandom),
           ($urandom % 8) == 0, $urandom, ($urandom % 5) == 0, 3'($urandom),
           $urandom, mtag[md]);
      if (n % 60 == 0) begin
        for (int i = 0; i < 8; i++) chk_reg(3'(i), "R10 random");
        chk_mask("R2 random");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule